// File: doc/BRIEF.md
# NVM Word Checksum Sequencer

This block walks a word-addressed nonvolatile store to check or regenerate its 16-bit additive checksum. After a start pulse it fetches words one by one, starting at address 0, through a single-outstanding read port, and keeps a running sum that wraps at 16 bits. In check mode the sum covers the checksum word itself, and the result passes only when the sum equals the signature 0xBABA. In regenerate mode the sum stops just before the checksum word, and the block issues one write that stores the signature minus that sum at the checksum address.

A read that returns an error ends the run at once. The block then reports an error and makes no write. The three result flags (done, pass, error) stay as they are until the next start is accepted.

The controller has four states. IDLE is the state after reset. READ holds a read request until a response arrives. WRITE holds the checksum write until it is acknowledged. DONE presents the result.

The transitions are:
- IDLE or DONE to READ on start (launch).
- IDLE or DONE straight to WRITE on start in regenerate mode when the checksum address is 0 (empty launch).
- READ to READ on a clean response that is not the last (advance).
- READ to DONE on an error response (abort), or on the last clean response in check mode (verdict).
- READ to WRITE on the last clean response in regenerate mode (commit).
- WRITE to DONE on the write acknowledge (stored).

Top module: `nvm_csum_seq`

## Requirements
- R1: After reset, done_o, pass_o, error_o, rd_req_o and wr_req_o are all low.
- R2: In check mode the block reads addresses 0 through CSUM_ADDR (default 63) in ascending order, one at a time. rd_addr_o stays stable while rd_req_o is high without rd_ack_i, and it steps by one after each clean response.
- R3: The running sum is 16 bits wide and wraps modulo 65536. For example, words 0xFFFF and 0xBABB with all others zero sum to 0xBABA.
- R4: A check run ends with pass_o high exactly when the wrapped sum of words 0..CSUM_ADDR equals 0xBABA. A sum of zero fails.
- R5: A regenerate run reads words 0..CSUM_ADDR-1. It then raises wr_req_o with wr_addr_o = CSUM_ADDR and wr_data_o = 0xBABA minus the wrapped sum, holds them until wr_ack_i, and ends with pass_o high. A check run that follows then passes.
- R6: A response with rd_err_i high ends the run at that read, with error_o high and pass_o low. No further read and no write are issued.
- R7: done_o, pass_o and error_o hold their values until a start is accepted. done_o is low in the cycle after an accepted start.
- R8: start_i is ignored while a run is in READ or WRITE. The result and the completion cycle are unchanged.
- R9: done_o rises on the clock edge that accepts the final response (the last read, the error read, or the write acknowledge).
- R10: A check run never raises wr_req_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted in IDLE or DONE |
| op_i | input | 1 | 0 = check, 1 = regenerate; sampled with start |
| rd_req_o | output | 1 | Read request, held until response |
| rd_addr_o | output | ADDR_W | Word address of the read |
| rd_ack_i | input | 1 | Read response valid |
| rd_err_i | input | 1 | Read response carries an error |
| rd_data_i | input | WORD_W | Read response word |
| wr_req_o | output | 1 | Checksum write request, held until acknowledge |
| wr_addr_o | output | ADDR_W | Write address (checksum word) |
| wr_data_o | output | WORD_W | Corrected checksum word |
| wr_ack_i | input | 1 | Write acknowledge |
| done_o | output | 1 | Run finished |
| pass_o | output | 1 | Run succeeded |
| error_o | output | 1 | Run aborted by read error |

## Verification
Start is accepted on edge 0. Each transfer then completes on the edge where its acknowledge is sampled, so with a responder that answers after L idle cycles, a full run shows done_o after (CSUM_ADDR+1)(L+1) edges. An abort at address a shows done_o after (a+1)(L+1) edges. The bench counts edges from the start edge, samples on the falling edge, and compares the count at which done_o is first seen with these formulas for latencies 0 to 3. The responder also logs each acknowledged address and each write, so that order, count and write contents are compared once the run has ended.

// File: rtl/nvmck_pkg.sv
package nvmck_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } ck_state_t;

    typedef enum logic {
        OP_CHECK = 1'b0,
        OP_REGEN = 1'b1
    } ck_op_t;

endpackage

// File: rtl/nvmck_addr_ctr.sv
module nvmck_addr_ctr #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    input  logic [ADDR_W-1:0] last_addr,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (clr) begin
            addr <= '0;
        end else if (inc) begin
            addr <= addr + 1'b1;
        end
    end

    assign at_last = (addr == last_addr);

endmodule

// File: rtl/nvmck_accum.sv
module nvmck_accum #(
    parameter int          WORD_W    = 16,
    parameter logic [15:0] SIGNATURE = 16'hBABA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add,
    input  logic [WORD_W-1:0] din,
    output logic              sum_hit,
    output logic [WORD_W-1:0] fix_word
);

    localparam logic [WORD_W-1:0] SIG_W = WORD_W'(SIGNATURE);

    logic [WORD_W-1:0] sum_q;
    logic [WORD_W-1:0] sum_next;

    assign sum_next = sum_q + din;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (clr) begin
            sum_q <= '0;
        end else if (add) begin
            sum_q <= sum_next;
        end
    end

    // verdict uses the sum including the word now arriving
    assign sum_hit  = (sum_next == SIG_W);
    assign fix_word = SIG_W - sum_q;

endmodule

// File: rtl/nvmck_ctrl.sv
module nvmck_ctrl
    import nvmck_pkg::*;
#(
    parameter int CSUM_ADDR = 63
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic op,
    input  logic rd_ack,
    input  logic rd_err,
    input  logic wr_ack,
    input  logic at_last,
    input  logic sum_hit,
    output logic rd_req,
    output logic wr_req,
    output logic done,
    output logic pass,
    output logic error,
    output logic regen,
    output logic launch,
    output logic step
);

    localparam bit SKIP_READS = (CSUM_ADDR == 0);

    ck_state_t state;
    ck_op_t    op_q;
    logic      pass_q;
    logic      err_q;
    logic      clean_ack;

    assign clean_ack = (state == ST_READ) && rd_ack && !rd_err;

    // state register and result flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            op_q   <= OP_CHECK;
            pass_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        op_q   <= ck_op_t'(op);
                        pass_q <= 1'b0;
                        err_q  <= 1'b0;
                        if (op && SKIP_READS) state <= ST_WRITE;
                        else                  state <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (rd_ack) begin
                        if (rd_err) begin
                            err_q <= 1'b1;
                            state <= ST_DONE;
                        end else if (at_last) begin
                            if (op_q == OP_CHECK) begin
                                pass_q <= sum_hit;
                                state  <= ST_DONE;
                            end else begin
                                state <= ST_WRITE;
                            end
                        end
                    end
                end
                ST_WRITE: begin
                    if (wr_ack) begin
                        pass_q <= 1'b1;
                        state  <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        rd_req = (state == ST_READ);
        wr_req = (state == ST_WRITE);
        done   = (state == ST_DONE);
        pass   = pass_q;
        error  = err_q;
        regen  = (op_q == OP_REGEN);
        launch = ((state == ST_IDLE) || (state == ST_DONE)) && start;
        step   = clean_ack;
    end

    assert_no_write_check_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (op_q == OP_REGEN));

    assert_err_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack && rd_err) |=> (done && error && !pass && !wr_req && !rd_req));

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass) && $stable(error)));

    assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_req || wr_req) && start && !rd_ack && !wr_ack) |=> (rd_req || wr_req));

    assert_write_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ack) |=> (done && pass && !error));

endmodule

// File: rtl/nvm_csum_seq.sv
module nvm_csum_seq #(
    parameter int          ADDR_W    = 6,
    parameter int          WORD_W    = 16,
    parameter int          CSUM_ADDR = 63,
    parameter logic [15:0] SIGNATURE = 16'hBABA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic              rd_err_i,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic              wr_req_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [WORD_W-1:0] wr_data_o,
    input  logic              wr_ack_i,
    output logic              done_o,
    output logic              pass_o,
    output logic              error_o
);

    localparam logic [ADDR_W-1:0] CHECK_LAST = ADDR_W'(CSUM_ADDR);
    localparam logic [ADDR_W-1:0] REGEN_LAST =
        ADDR_W'((CSUM_ADDR == 0) ? 0 : CSUM_ADDR - 1);

    logic              regen;
    logic              launch;
    logic              step;
    logic              at_last;
    logic              sum_hit;
    logic [ADDR_W-1:0] last_addr;

    assign last_addr = regen ? REGEN_LAST : CHECK_LAST;

    nvmck_ctrl #(
        .CSUM_ADDR (CSUM_ADDR)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_i),
        .op      (op_i),
        .rd_ack  (rd_ack_i),
        .rd_err  (rd_err_i),
        .wr_ack  (wr_ack_i),
        .at_last (at_last),
        .sum_hit (sum_hit),
        .rd_req  (rd_req_o),
        .wr_req  (wr_req_o),
        .done    (done_o),
        .pass    (pass_o),
        .error   (error_o),
        .regen   (regen),
        .launch  (launch),
        .step    (step)
    );

    nvmck_addr_ctr #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (launch),
        .inc       (step && !at_last),
        .last_addr (last_addr),
        .addr      (rd_addr_o),
        .at_last   (at_last)
    );

    nvmck_accum #(
        .WORD_W    (WORD_W),
        .SIGNATURE (SIGNATURE)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (launch),
        .add      (step),
        .din      (rd_data_i),
        .sum_hit  (sum_hit),
        .fix_word (wr_data_o)
    );

    assign wr_addr_o = CHECK_LAST;

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_ack_i && !rd_err_i) |=>
            (!rd_req_o || (rd_addr_o == $past(rd_addr_o) + 1'b1)));

    assert_one_port_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_o && wr_req_o));

    assert_flags_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(pass_o && error_o));

endmodule

// File: tb/nvm_csum_seq_bench.sv
module nvm_csum_seq_bench;

    localparam int CS   = 63;
    localparam int NW   = CS + 1;
    localparam logic [15:0] SIG = 16'hBABA;

    // vector fields: [31] op, [30:29] latency, [28] fix checksum word,
    // [27] inject error, [26:21] error address, [15:0] fill seed
    localparam int NV = 9;
    localparam logic [31:0] VEC [NV] = '{
        {1'b0, 2'd0, 1'b1, 1'b0, 6'd0,  5'd0, 16'h1234},
        {1'b0, 2'd1, 1'b0, 1'b0, 6'd0,  5'd0, 16'h0F0F},
        {1'b1, 2'd0, 1'b0, 1'b0, 6'd0,  5'd0, 16'hA5A5},
        {1'b1, 2'd2, 1'b0, 1'b0, 6'd0,  5'd0, 16'h7777},
        {1'b0, 2'd3, 1'b1, 1'b0, 6'd0,  5'd0, 16'hFFFF},
        {1'b0, 2'd0, 1'b0, 1'b1, 6'd17, 5'd0, 16'h3C3C},
        {1'b1, 2'd1, 1'b0, 1'b1, 6'd62, 5'd0, 16'h0101},
        {1'b0, 2'd0, 1'b1, 1'b1, 6'd63, 5'd0, 16'h4242},
        {1'b1, 2'd0, 1'b0, 1'b1, 6'd0,  5'd0, 16'h9999}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        op_i = 1'b0;
    logic        rd_req_o;
    logic [5:0]  rd_addr_o;
    logic        rd_ack_i = 1'b0;
    logic        rd_err_i = 1'b0;
    logic [15:0] rd_data_i = '0;
    logic        wr_req_o;
    logic [5:0]  wr_addr_o;
    logic [15:0] wr_data_o;
    logic        wr_ack_i = 1'b0;
    logic        done_o;
    logic        pass_o;
    logic        error_o;

    nvm_csum_seq u_nvm_csum_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .op_i      (op_i),
        .rd_req_o  (rd_req_o),
        .rd_addr_o (rd_addr_o),
        .rd_ack_i  (rd_ack_i),
        .rd_err_i  (rd_err_i),
        .rd_data_i (rd_data_i),
        .wr_req_o  (wr_req_o),
        .wr_addr_o (wr_addr_o),
        .wr_data_o (wr_data_o),
        .wr_ack_i  (wr_ack_i),
        .done_o    (done_o),
        .pass_o    (pass_o),
        .error_o   (error_o)
    );

    always #10 clk = ~clk;

    logic [15:0] mem [NW];
    int lat = 0;
    bit err_en = 1'b0;
    int err_addr = 0;
    int wcnt = 0;
    int exp_addr = 0;
    int nreads = 0;
    int order_bad = 0;
    int nwrites = 0;
    int wr_seen_addr = 0;
    logic [15:0] wr_seen_data = '0;
    int tests = 0;
    int fails = 0;
    int cycles_total = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] sum_to(input int n);
        logic [15:0] s = '0;
        for (int i = 0; i < n; i++) s = s + mem[i];
        return s;
    endfunction

    // memory responder: answers after lat idle cycles, logs traffic
    always @(negedge clk) begin
        cycles_total++;
        rd_ack_i <= 1'b0;
        rd_err_i <= 1'b0;
        wr_ack_i <= 1'b0;
        if (rd_req_o || wr_req_o) begin
            if (wcnt >= lat) begin
                wcnt <= 0;
                if (rd_req_o) begin
                    rd_ack_i  <= 1'b1;
                    rd_data_i <= mem[int'(rd_addr_o)];
                    rd_err_i  <= err_en && (int'(rd_addr_o) == err_addr);
                    if (int'(rd_addr_o) != exp_addr) order_bad <= order_bad + 1;
                    exp_addr  <= exp_addr + 1;
                    nreads    <= nreads + 1;
                end else begin
                    wr_ack_i     <= 1'b1;
                    wr_seen_addr <= int'(wr_addr_o);
                    wr_seen_data <= wr_data_o;
                    mem[int'(wr_addr_o)] <= wr_data_o;
                    nwrites      <= nwrites + 1;
                end
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            wcnt <= 0;
        end
    end

    // run one operation; poke >= 0 pulses start at that edge count while busy
    task automatic run_op(input bit op, input int poke, output int cyc);
        @(negedge clk);
        start_i   = 1'b1;
        op_i      = op;
        exp_addr  = 0;
        nreads    = 0;
        order_bad = 0;
        nwrites   = 0;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        chk("R7 done low after accepted start", {31'd0, done_o}, 32'd0);
        while (!done_o && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            start_i = (cyc == poke);
        end
        start_i = 1'b0;
        if (cyc >= 5000) chk("R9 run did not finish", 32'd1, 32'd0);
    endtask

    initial begin : watchdog
        wait (cycles_total > 150000);
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles_total);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        int cyc;
        logic [15:0] exp_sum;
        for (int i = 0; i < NW; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        chk("R1 done at reset", {31'd0, done_o}, 32'd0);
        chk("R1 pass at reset", {31'd0, pass_o}, 32'd0);
        chk("R1 error at reset", {31'd0, error_o}, 32'd0);
        chk("R1 requests at reset", {30'd0, rd_req_o, wr_req_o}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", {29'd0, rd_req_o, wr_req_o, done_o}, 32'd0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            bit op;
            int l;
            int ea;
            bit ee;
            int exp_cyc;
            op = VEC[v][31];
            l  = int'(VEC[v][30:29]);
            ee = VEC[v][27];
            ea = int'(VEC[v][26:21]);
            for (int i = 0; i < NW; i++)
                mem[i] = VEC[v][15:0] * 16'(i + 3) ^ 16'(i << 9);
            if (VEC[v][28]) mem[CS] = SIG - sum_to(CS);
            lat = l;
            err_en = ee;
            err_addr = ea;
            exp_sum = op ? sum_to(CS) : sum_to(NW);
            run_op(op, -1, cyc);
            if (ee) begin
                chk("R6 error flag", {31'd0, error_o}, 32'd1);
                chk("R6 pass low on error", {31'd0, pass_o}, 32'd0);
                chk("R6 reads stop at error", nreads, ea + 1);
                chk("R6 no write after error", nwrites, 0);
                chk("R9 abort timing", cyc, (ea + 1) * (l + 1));
            end else if (!op) begin
                chk("R4 check verdict", {31'd0, pass_o}, {31'd0, exp_sum == SIG});
                chk("R4 no error", {31'd0, error_o}, 32'd0);
                chk("R2 read count", nreads, NW);
                chk("R10 no write in check", nwrites, 0);
                chk("R9 check timing", cyc, NW * (l + 1));
            end else begin
                chk("R5 pass after write", {31'd0, pass_o}, 32'd1);
                chk("R5 read count", nreads, CS);
                chk("R5 one write", nwrites, 1);
                chk("R5 write address", wr_seen_addr, CS);
                chk("R5 write data", {16'd0, wr_seen_data}, {16'd0, SIG - exp_sum});
                chk("R9 regen timing", cyc, NW * (l + 1));
                err_en = 1'b0;
                run_op(1'b0, -1, cyc);
                chk("R5 check passes after regen", {31'd0, pass_o}, 32'd1);
            end
            chk("R2 ascending order", order_bad, 0);
        end

        // zero sum must fail
        lat = 0;
        err_en = 1'b0;
        for (int i = 0; i < NW; i++) mem[i] = '0;
        run_op(1'b0, -1, cyc);
        chk("R4 zero sum fails", {30'd0, pass_o, error_o}, 32'd0);

        // wrap: all ones
        for (int i = 0; i < NW; i++) mem[i] = 16'hFFFF;
        run_op(1'b0, -1, cyc);
        chk("R3 all-ones sum fails", {31'd0, pass_o}, 32'd0);
        run_op(1'b1, -1, cyc);
        chk("R3 wrapped fix word", {16'd0, wr_seen_data}, 32'h0000BAF9);
        run_op(1'b0, -1, cyc);
        chk("R3 passes after wrapped fix", {31'd0, pass_o}, 32'd1);

        // wrap carries out to exactly the signature
        for (int i = 0; i < NW; i++) mem[i] = '0;
        mem[0] = 16'hFFFF;
        mem[1] = 16'hBABB;
        run_op(1'b0, -1, cyc);
        chk("R3 carry dropped, sum hits signature", {31'd0, pass_o}, 32'd1);

        // start while busy is ignored
        lat = 1;
        run_op(1'b0, 10, cyc);
        chk("R8 result unchanged by busy start", {30'd0, pass_o, error_o}, 32'd2);
        chk("R8 timing unchanged by busy start", cyc, NW * 2);
        chk("R8 read count unchanged", nreads, NW);

        // results hold until next start
        repeat (20) @(negedge clk);
        chk("R7 flags held", {29'd0, done_o, pass_o, error_o}, 32'd6);
        err_en = 1'b1;
        err_addr = 5;
        lat = 0;
        run_op(1'b0, -1, cyc);
        chk("R6 error after earlier pass", {30'd0, pass_o, error_o}, 32'd1);
        repeat (15) @(negedge clk);
        chk("R7 error held", {29'd0, done_o, pass_o, error_o}, 32'd5);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule